// File: doc/BRIEF.md
# Pipelined Four-Function Prefix ALU

This block is an 8-bit arithmetic logic unit that computes one of four functions on a pair of operands: bitwise AND, bitwise OR, bitwise XOR, or a sum with carry-in. Each operation travels through two register stages. The first stage captures the opcode, the operands and the carry-in. The second stage holds the 8-bit result and a carry-out. The combinational logic between the two stages has a fixed structure. A pair of per-bit cells, each set by a 4-bit truth table, forms the propagate and generate terms. A Han-Carlson parallel-prefix network then resolves the carries. It combines odd bit positions only, in log2(W) levels, and adds one more level for the even positions. A final sum stage and function selection follow. In logic modes the propagate cell's table is the chosen function, and the cell output goes straight to the result.

Operations arrive on a valid/ready stream and results leave on another. A transfer on either side takes place at a rising edge where valid and ready are both high. While its valid is high and ready is low, the upstream side must hold the opcode, operands and carry-in steady. The block keeps its output payload steady under the same condition. in_ready depends combinationally on out_ready. It is high whenever the first stage is empty, or when the first stage can move forward because the output register is empty or is being read. With out_ready held high the block accepts one operation per clock.

Top module: `prefix_alu`

## Requirements
- R1: A synchronous active-high reset clears both stages. After a reset edge, out_valid is 0, in_ready is 1, out_result is 0 and out_cout is 0, and any operation held in the pipeline is discarded.
- R2: Opcode 2'b00 returns the bitwise AND of the two operands.
- R3: Opcode 2'b01 returns the bitwise OR of the two operands.
- R4: Opcode 2'b10 returns the bitwise XOR of the two operands.
- R5: Opcode 2'b11 returns the sum: {out_cout, out_result} equals a + b + cin as a 9-bit value. The carries come from the prefix network.
- R6: In the three logic opcodes, out_cout is 0 and in_cin has no effect on out_result.
- R7: An operation accepted at edge k is presented at the outputs after edge k+1, with out_valid high from that point. While out_ready stays high, in_ready stays high and one operation is taken per cycle.
- R8: While out_valid is high and out_ready is low, out_result and out_cout hold their values. in_ready is low while both stages are occupied. Every accepted operation is delivered exactly once and in the order it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take the offered operation |
| in_op | input | 2 | Function: 00 AND, 01 OR, 10 XOR, 11 add |
| in_a | input | W (8) | First operand |
| in_b | input | W (8) | Second operand |
| in_cin | input | 1 | Carry into bit 0, used only by the add function |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | W (8) | Result bits |
| out_cout | output | 1 | Carry out of the top bit; 0 in logic modes |

## Verification
The hardest case to reach from the ports is a carry that must ripple through every level of the prefix tree. This happens when every bit propagates and only the carry-in starts the chain. It is reached with a sweep of each operand against its complement, with carry-in both low and high. That sweep follows an exhaustive sum sweep over all operand pairs. The second hard state is the point where both stages are full under back-pressure. Here in_ready must fall, and the held result must stay unchanged. To reach it, the bench holds out_ready low while it offers three operations in a row. It then adds a long phase in which valid gaps and ready stalls come from a shift-register pattern.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    ALU_AND = 2'b00,
    ALU_OR  = 2'b01,
    ALU_XOR = 2'b10,
    ALU_ADD = 2'b11
  } alu_op_e;

  // Truth tables indexed by {a_bit, b_bit}: entry 3 is a=1,b=1, entry 0 is a=0,b=0.
  localparam logic [3:0] TT_ZERO = 4'b0000;
  localparam logic [3:0] TT_AND  = 4'b1000;
  localparam logic [3:0] TT_OR   = 4'b1110;
  localparam logic [3:0] TT_XOR  = 4'b0110;

  typedef struct packed {
    logic [3:0] p_tt;   // table for the propagate cell
    logic [3:0] g_tt;   // table for the generate cell
    logic       arith;  // carry network drives the result
  } cell_cfg_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  alu_op_e   op,
  output cell_cfg_t cfg
);

  always_comb begin
    cfg = '{p_tt: TT_ZERO, g_tt: TT_ZERO, arith: 1'b0};
    unique case (op)
      ALU_AND: cfg.p_tt = TT_AND;
      ALU_OR:  cfg.p_tt = TT_OR;
      ALU_XOR: cfg.p_tt = TT_XOR;
      ALU_ADD: begin
        cfg.p_tt  = TT_XOR;
        cfg.g_tt  = TT_AND;
        cfg.arith = 1'b1;
      end
      default: cfg = '{p_tt: TT_ZERO, g_tt: TT_ZERO, arith: 1'b0};
    endcase
  end

endmodule

// File: rtl/alu_pg_cell.sv
module alu_pg_cell #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   p_tt,
  input  logic [3:0]   g_tt,
  output logic [W-1:0] p,
  output logic [W-1:0] g
);

  // Each bit looks up its two-input function in the programmed table.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] idx;
    assign idx  = {a[i], b[i]};
    assign p[i] = p_tt[idx];
    assign g[i] = g_tt[idx];
  end

endmodule

// File: rtl/alu_hc_tree.sv
module alu_hc_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] g,
  input  logic [W-1:0] p,
  input  logic         cin,
  output logic [W:0]   carry
);

  localparam int H = W / 2;
  localparam int L = $clog2(W);

  logic [W-1:0] g0;   // generate with carry-in folded into bit 0
  logic [H-1:0] tg;   // group generate of odd node k (bit 2k+1)
  logic [H-1:0] tp;   // group propagate of odd node k

  assign g0 = {g[W-1:1], g[0] | (p[0] & cin)};

  // Odd-position tree: first level pairs each odd bit with its even
  // neighbour, then L-1 levels of doubling spans among odd nodes only.
  // Descending node order keeps each partner at its previous level value.
  always_comb begin
    for (int k = 0; k < H; k++) begin
      tg[k] = g0[2*k+1] | (p[2*k+1] & g0[2*k]);
      tp[k] = p[2*k+1] & p[2*k];
    end
    for (int s = 1; s < L; s++) begin
      for (int k = H - 1; k >= (1 << (s - 1)); k--) begin
        tg[k] = tg[k] | (tp[k] & tg[k - (1 << (s - 1))]);
        tp[k] = tp[k] & tp[k - (1 << (s - 1))];
      end
    end
  end

  // Closing level: even positions take their odd neighbour's prefix.
  assign carry[0] = cin;
  for (genvar k = 0; k < H; k++) begin : g_even
    assign carry[2*k+2] = tg[k];
    if (k == 0) begin : g_low
      assign carry[1] = g0[0];
    end else begin : g_high
      assign carry[2*k+1] = g0[2*k] | (p[2*k] & tg[k-1]);
    end
  end

endmodule

// File: rtl/prefix_alu.sv
module prefix_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_cin,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_cout
);

  // ---------------- operand stage ----------------
  logic         in_vld_q;
  alu_op_e      op_q;
  logic [W-1:0] a_q, b_q;
  logic         cin_q;

  // ---------------- result stage ----------------
  logic         out_vld_q;
  logic [W-1:0] res_q;
  logic         cout_q;

  logic adv_out;
  assign adv_out  = !out_vld_q || out_ready;
  assign in_ready = !in_vld_q || adv_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_vld_q <= 1'b0;
      op_q     <= ALU_AND;
      a_q      <= '0;
      b_q      <= '0;
      cin_q    <= 1'b0;
    end else if (in_ready) begin
      in_vld_q <= in_valid;
      if (in_valid) begin
        op_q  <= alu_op_e'(in_op);
        a_q   <= in_a;
        b_q   <= in_b;
        cin_q <= in_cin;
      end
    end
  end

  // ---------------- combinational datapath ----------------
  cell_cfg_t    cfg;
  logic [W-1:0] p_w, g_w, sum_w, res_w;
  logic [W:0]   carry;
  logic         cin_eff, cout_w;

  alu_op_decode u_dec (
    .op  (op_q),
    .cfg (cfg)
  );

  alu_pg_cell #(.W(W)) u_cells (
    .a    (a_q),
    .b    (b_q),
    .p_tt (cfg.p_tt),
    .g_tt (cfg.g_tt),
    .p    (p_w),
    .g    (g_w)
  );

  assign cin_eff = cin_q & cfg.arith;

  alu_hc_tree #(.W(W)) u_tree (
    .g     (g_w),
    .p     (p_w),
    .cin   (cin_eff),
    .carry (carry)
  );

  assign sum_w  = p_w ^ carry[W-1:0];
  assign res_w  = cfg.arith ? sum_w : p_w;
  assign cout_w = cfg.arith & carry[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_q <= 1'b0;
      res_q     <= '0;
      cout_q    <= 1'b0;
    end else if (adv_out) begin
      out_vld_q <= in_vld_q;
      if (in_vld_q) begin
        res_q  <= res_w;
        cout_q <= cout_w;
      end
    end
  end

  assign out_valid  = out_vld_q;
  assign out_result = res_q;
  assign out_cout   = cout_q;

  // ---------------- assertions ----------------
  assert_reset_clear_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!out_vld_q && !in_vld_q));

  assert_sum_value_R5: assert property (@(posedge clk) disable iff (rst)
    (in_vld_q && op_q == ALU_ADD) |->
      ({cout_w, res_w} == ({1'b0, a_q} + {1'b0, b_q} + {{W{1'b0}}, cin_q})));

  for (genvar i = 0; i < W; i++) begin : g_carry_chk
    assert_kill_gen_R5: assert property (@(posedge clk) disable iff (rst)
      (in_vld_q && op_q == ALU_ADD && !p_w[i]) |-> (carry[i+1] == g_w[i]));
    assert_pass_R5: assert property (@(posedge clk) disable iff (rst)
      (in_vld_q && op_q == ALU_ADD && p_w[i]) |-> (carry[i+1] == carry[i]));
  end

  assert_logic_no_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (in_vld_q && op_q != ALU_ADD && adv_out) |=> (out_cout == 1'b0));

  assert_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (in_vld_q && adv_out) |=> out_vld_q);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_vld_q && !out_ready) |=> (out_vld_q && $stable(res_q) && $stable(cout_q)));

  assert_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (in_vld_q && !adv_out) |=> (in_vld_q && $stable(a_q) && $stable(b_q) && $stable(op_q)));

endmodule

// File: tb/tb_prefix_alu.sv
module tb_prefix_alu;
  localparam int W = 8;
  localparam int N_STREAM = 66048 + 39936;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = 2'b00;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_cin = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_result;
  logic         out_cout;

  int checks = 0;
  int errors = 0;
  logic [10:0] expq[$];

  prefix_alu #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_cout(out_cout)
  );

  function automatic logic [8:0] model(input logic [1:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic c);
    case (op)
      2'd0:    model = {1'b0, a & b};
      2'd1:    model = {1'b0, a | b};
      2'd2:    model = {1'b0, a ^ b};
      default: model = 9'(a) + 9'(b) + 9'(c);
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'd0:    req_of = "R2";
      2'd1:    req_of = "R3";
      2'd2:    req_of = "R4";
      default: req_of = "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic take_out();
    logic [10:0] e;
    if (expq.size() == 0) begin
      check("R8", "output with nothing pending", 1, 0);
      return;
    end
    e = expq.pop_front();
    check(req_of(e[10:9]), "result", int'(out_result), int'(e[7:0]));
    check((e[10:9] == 2'd3) ? "R5" : "R6", "carry out", int'(out_cout), int'(e[8]));
  endtask

  // One clock: drive at the falling edge, observe handshakes before the rising edge.
  task automatic cycle(input logic ordy, input logic ivld, input logic [1:0] op,
                       input logic [7:0] a, input logic [7:0] b, input logic c,
                       output logic took);
    @(negedge clk);
    out_ready = ordy;
    in_valid  = ivld;
    in_op     = op;
    in_a      = a;
    in_b      = b;
    in_cin    = c;
    #1;
    if (out_valid && out_ready) take_out();
    took = in_valid && in_ready;
    if (took) expq.push_back({op, model(op, a, b, c)});
  endtask

  task automatic gen(input int n, output logic [1:0] op, output logic [7:0] a,
                     output logic [7:0] b, output logic c);
    int m, r;
    if (n < 65536) begin
      op = 2'd3; a = 8'(n >> 8); b = 8'(n); c = n[0] ^ n[8];
    end else if (n < 66048) begin
      m = n - 65536;
      op = 2'd3; a = 8'(m >> 1); b = ~a; c = m[0];
    end else begin
      m = n - 66048;
      op = 2'(m / 13312);
      r = m % 13312;
      a = 8'(r / 52); b = 8'((r % 52) * 5); c = r[0];
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic took, c, pend;
    logic [1:0] op;
    logic [7:0] a, b;
    logic [8:0] held;
    logic [15:0] lfsr;
    int stalls;

    // R1: state under reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "in_ready in reset", int'(in_ready), 1);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "out_result in reset", int'(out_result), 0);
    check("R1", "out_cout in reset", int'(out_cout), 0);
    rst = 1'b0;

    // R7: two-edge latency
    cycle(1'b1, 1'b1, 2'd3, 8'd100, 8'd27, 1'b1, took);
    check("R7", "first accept", int'(took), 1);
    cycle(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 1'b0, took);
    check("R7", "out_valid after one edge", int'(out_valid), 0);
    cycle(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 1'b0, took);
    check("R7", "out_valid after two edges", int'(out_valid), 1);
    cycle(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 1'b0, took);

    // R2..R6: full-rate sweeps (exhaustive sum, full-propagate chains, logic grid)
    stalls = 0;
    for (int n = 0; n < N_STREAM; n++) begin
      gen(n, op, a, b, c);
      cycle(1'b1, 1'b1, op, a, b, c, took);
      if (!took) stalls++;
    end
    repeat (4) cycle(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 1'b0, took);
    check("R7", "refused offers at full rate", stalls, 0);
    check("R8", "pending after full-rate drain", expq.size(), 0);

    // R8: random valid gaps and ready stalls
    lfsr = 16'hACE1;
    pend = 1'b0;
    op = 2'd0; a = 8'd0; b = 8'd0; c = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!pend) begin
        op = lfsr[9:8];
        a = lfsr[7:0] ^ 8'(i);
        b = lfsr[15:8] + 8'(i * 3);
        c = lfsr[4];
        pend = lfsr[2] | lfsr[6];
      end
      cycle(lfsr[1] | lfsr[11], pend, op, a, b, c, took);
      if (took) pend = 1'b0;
    end
    repeat (6) cycle(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 1'b0, took);
    check("R8", "pending after stall drain", expq.size(), 0);

    // R8: both stages full with output stalled
    cycle(1'b0, 1'b1, 2'd3, 8'd200, 8'd100, 1'b1, took);
    check("R8", "accept into empty pipe", int'(took), 1);
    cycle(1'b0, 1'b1, 2'd2, 8'hF0, 8'h3C, 1'b0, took);
    check("R8", "accept second", int'(took), 1);
    cycle(1'b0, 1'b1, 2'd1, 8'h81, 8'h18, 1'b1, took);
    check("R8", "third refused", int'(took), 0);
    check("R8", "in_ready when full", int'(in_ready), 0);
    check("R8", "stalled out_valid", int'(out_valid), 1);
    check("R5", "stalled sum 200+100+1", int'({out_cout, out_result}), 301);
    held = {out_cout, out_result};
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 1'b1, 2'd1, 8'h81, 8'h18, 1'b1, took);
      check("R8", "refused while stalled", int'(took), 0);
      check("R8", "held output", int'({out_cout, out_result}), int'(held));
    end
    for (int k = 0; k < 5 && !took; k++)
      cycle(1'b1, 1'b1, 2'd1, 8'h81, 8'h18, 1'b1, took);
    repeat (4) cycle(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 1'b0, took);
    check("R8", "pending after release", expq.size(), 0);

    // R1: reset with the pipeline occupied
    cycle(1'b0, 1'b1, 2'd0, 8'hFF, 8'h0F, 1'b0, took);
    cycle(1'b0, 1'b1, 2'd3, 8'd9, 8'd9, 1'b0, took);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "in_ready after reset", int'(in_ready), 1);
    check("R1", "out_result after reset", int'(out_result), 0);
    expq.delete();
    rst = 1'b0;
    cycle(1'b1, 1'b1, 2'd3, 8'd255, 8'd1, 1'b0, took);
    cycle(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 1'b0, took);
    check("R1", "no stale output after reset", int'(out_valid), 0);
    cycle(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 1'b0, took);
    check("R5", "255+1 wraps with carry", int'({out_cout, out_result}), 256);
    repeat (2) cycle(1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 1'b0, took);
    check("R8", "pending at end", expq.size(), 0);

    summary();
    $finish;
  end

endmodule